// File: doc/BRIEF.md
# Host Bus Cycle Bridge

This block connects the fast 8-bit bus of an internal CPU to the slow bus of a 6502-style host. The host supplies its own Phi0 clock, which has no fixed relation to the fast clock. Every CPU access goes through an address decoder. An access that misses the host I/O windows is marked local and is served inside the chip with no delay. An access that hits a window freezes the CPU. The bridge then runs one complete host bus cycle, timed by the host's own Phi0, and releases the CPU with a single-cycle completion pulse.

Phi0 is brought into the fast domain through a flop chain, and its edges are found from the synchronised samples. Address and direction are launched after a falling edge. Write data is enabled onto the host bus only while Phi0 is high. A read byte is captured a fixed number of fast clocks before the falling edge. The bridge predicts that edge from the length of the previous high phase, so the same design serves slow and fast hosts. The CPU keeps its request, address, direction and write data steady for as long as it is stalled.

Top module: `hbb_bridge`

## Requirements
- R1: A request with `cpu_req`=1 whose address lies in no I/O window sets `cpu_local`=1 in the same cycle. It keeps `cpu_stall`=0 and starts no host cycle: `host_rw` stays 1 and `host_d_oe` stays 0.
- R2: A request that hits a window raises `cpu_stall` in the same cycle. `cpu_stall` stays high until the cycle in which `cpu_done` pulses for exactly one clock. `cpu_stall` is 0 in that done cycle, and stall falls only into a done cycle.
- R3: The address and the direction (`host_rw`=1 read, 0 write) are driven one clock after the first synchronised Phi0 falling edge seen at or after the request cycle. Both are valid at the next Phi0 rise. `host_rw` is back to 1 by the done cycle, and `host_a` changes only while an access is in progress.
- R4: In a write, `host_d_out` carries the CPU byte and `host_d_oe`=1 throughout the Phi0 high phase. Exactly one high phase sees `host_rw`=0. `host_d_oe` is only ever 1 while `host_rw`=0, and it drops at the synchronised falling edge, before any later address change.
- R5: In a read, once a previous high phase has been measured, the byte on `host_d_in` is captured `RD_LEAD` fast clocks before the synchronised falling edge. That byte appears on `cpu_rdata` in the done cycle.
- R6: If no complete high phase (a rise followed by a fall) has been measured since reset, the read byte is captured in the cycle the synchronised falling edge is detected.
- R7: A request presented in the done cycle is ignored (`cpu_stall`=0 there). When it is still presented in the following cycle, it is accepted as a new access.
- R8: Behaviour is correct for Phi0 high and low phases from 20 up to 1000 fast clocks, including unequal high and low lengths.
- R9: During and after reset, before any request: `cpu_stall`=0, `cpu_done`=0, `host_rw`=1, `host_d_oe`=0, `host_a`=0.
- R10: Windows are inclusive at both bounds. By default they cover 0xC000–0xC0FF and 0xE800–0xE80F, so 0xBFFF, 0xC100, 0xE7FF and 0xE810 are local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access valid, held while stalled |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_local | output | 1 | Access served internally |
| cpu_stall | output | 1 | Freeze the CPU |
| cpu_done | output | 1 | One-cycle completion of a host access |
| cpu_rdata | output | 8 | Byte read from the host, valid with cpu_done |
| phi0_in | input | 1 | Host Phi0 clock, asynchronous |
| host_a | output | 16 | Host address bus |
| host_rw | output | 1 | Host direction, 1 = read |
| host_d_out | output | 8 | Host data bus, driven value |
| host_d_oe | output | 1 | Host data bus drive enable |
| host_d_in | input | 8 | Host data bus, sampled value |

## Verification
Two events can fall in the same cycle. An I/O request can arrive in the very cycle a synchronised falling edge is detected, and it must then launch on that edge rather than wait a whole Phi0 period. A new request can also be presented in the done cycle itself, where it must be ignored and then accepted one cycle later. The bench provokes the first by issuing requests after random idle gaps of up to one Phi0 period at three Phi0 speeds, which sweeps the issue point across every phase offset. It provokes the second by switching the CPU address to the next I/O target inside the done cycle. Both are judged at the host pins: the address and direction seen at the data-phase rise, the write byte and drive enable just before the fall, and the returned read byte. The host model drives the inverted byte outside the high phase, so a capture at the wrong point shows up in the returned byte.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FALL,
        ST_ADDR,
        ST_HIGH,
        ST_DONE
    } cyc_state_e;

endpackage

// File: rtl/hbb_phi_sync.sv
module hbb_phi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi_raw,
    output logic phi_s,
    output logic phi_rise,
    output logic phi_fall
);
    localparam int ARM_W = $clog2(STAGES + 2);
    localparam logic [ARM_W-1:0] ARM_DONE = ARM_W'(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
        logic [ARM_W-1:0]  arm;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  armed;

    // Edges are honoured only once the chain and the history flop hold real samples
    assign armed = (sync_q.arm == ARM_DONE);

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], phi_raw};
        sync_d.prev  = sync_q.chain[STAGES-1];
        if (!armed) begin
            sync_d.arm = sync_q.arm + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign phi_s    = sync_q.chain[STAGES-1];
    assign phi_rise = armed &  phi_s & ~sync_q.prev;
    assign phi_fall = armed & ~phi_s &  sync_q.prev;

endmodule

// File: rtl/hbb_phase_meter.sv
module hbb_phase_meter #(
    parameter int CNT_W   = 10,
    parameter int RD_LEAD = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi_s,
    input  logic phi_rise,
    input  logic phi_fall,
    output logic latch_pt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LEAD    = CNT_W'(RD_LEAD);

    typedef struct packed {
        logic [CNT_W-1:0] hi_cnt;
        logic [CNT_W-1:0] last_high;
        logic             rise_seen;
        logic             len_ok;
    } meter_t;

    meter_t mtr_d, mtr_q;

    always_comb begin
        mtr_d = mtr_q;
        if (phi_s) begin
            mtr_d.hi_cnt = (mtr_q.hi_cnt == CNT_MAX) ? mtr_q.hi_cnt : mtr_q.hi_cnt + 1'b1;
        end else begin
            mtr_d.hi_cnt = '0;
        end
        if (phi_rise) begin
            mtr_d.rise_seen = 1'b1;
        end
        // A length is trusted only when the whole high phase was observed
        if (phi_fall && mtr_q.rise_seen) begin
            mtr_d.last_high = mtr_q.hi_cnt;
            mtr_d.len_ok    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mtr_q <= '0;
        end else begin
            mtr_q <= mtr_d;
        end
    end

    assign latch_pt = phi_s && mtr_q.len_ok && (mtr_q.last_high > LEAD)
                      && (mtr_q.hi_cnt == (mtr_q.last_high - LEAD));

endmodule

// File: rtl/hbb_io_decode.sv
module hbb_io_decode #(
    parameter int ADDR_W  = 16,
    parameter int NUM_WIN = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {16'hE800, 16'hC000},
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {16'hE80F, 16'hC0FF}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [NUM_WIN-1:0] win_hit;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign win_hit[g] = (addr >= WIN_LO[g*ADDR_W +: ADDR_W])
                         && (addr <= WIN_HI[g*ADDR_W +: ADDR_W]);
    end

    assign hit = |win_hit;

endmodule

// File: rtl/hbb_cycle_fsm.sv
module hbb_cycle_fsm
    import hbb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              io_hit,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              phi_rise,
    input  logic              phi_fall,
    input  logic              latch_pt,
    input  logic [DATA_W-1:0] host_d_in,
    output logic              cpu_stall,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] host_a,
    output logic              host_rw,
    output logic [DATA_W-1:0] host_d_out,
    output logic              host_d_oe
);
    typedef struct packed {
        cyc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              rw;
        logic [DATA_W-1:0] wdata;
        logic              oe;
        logic [DATA_W-1:0] rdata;
        logic              captured;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic accept;
    logic launch;

    assign accept = (fsm_q.state == ST_IDLE) && cpu_req && io_hit;
    // The CPU is frozen, so its address, direction and data are still valid here
    assign launch = phi_fall && (accept || (fsm_q.state == ST_WAIT_FALL));

    always_comb begin
        fsm_d = fsm_q;
        if (launch) begin
            fsm_d.addr     = cpu_addr;
            fsm_d.rw       = ~cpu_we;
            fsm_d.captured = 1'b0;
            if (cpu_we) begin
                fsm_d.wdata = cpu_wdata;
            end
        end
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (accept) begin
                    fsm_d.state = launch ? ST_ADDR : ST_WAIT_FALL;
                end
            end
            ST_WAIT_FALL: begin
                if (launch) begin
                    fsm_d.state = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (phi_rise) begin
                    fsm_d.state = ST_HIGH;
                    fsm_d.oe    = ~fsm_q.rw;
                end
            end
            ST_HIGH: begin
                if (phi_fall) begin
                    fsm_d.state = ST_DONE;
                    fsm_d.oe    = 1'b0;
                    fsm_d.rw    = 1'b1;
                    if (fsm_q.rw && !fsm_q.captured) begin
                        fsm_d.rdata = host_d_in;
                    end
                end else if (latch_pt && fsm_q.rw && !fsm_q.captured) begin
                    fsm_d.rdata    = host_d_in;
                    fsm_d.captured = 1'b1;
                end
            end
            ST_DONE: begin
                fsm_d.state = ST_IDLE;
            end
            default: begin
                fsm_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.state <= ST_IDLE;
            fsm_q.rw    <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign cpu_stall  = accept || (fsm_q.state == ST_WAIT_FALL)
                     || (fsm_q.state == ST_ADDR) || (fsm_q.state == ST_HIGH);
    assign cpu_done   = (fsm_q.state == ST_DONE);
    assign cpu_rdata  = fsm_q.rdata;
    assign host_a     = fsm_q.addr;
    assign host_rw    = fsm_q.rw;
    assign host_d_out = fsm_q.wdata;
    assign host_d_oe  = fsm_q.oe;

endmodule

// File: rtl/hbb_bridge.sv
module hbb_bridge #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 10,
    parameter int RD_LEAD     = 6,
    parameter int NUM_WIN     = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {16'hE800, 16'hC000},
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {16'hE80F, 16'hC0FF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_local,
    output logic              cpu_stall,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              phi0_in,
    output logic [ADDR_W-1:0] host_a,
    output logic              host_rw,
    output logic [DATA_W-1:0] host_d_out,
    output logic              host_d_oe,
    input  logic [DATA_W-1:0] host_d_in
);
    logic io_hit;
    logic phi_s;
    logic phi_rise;
    logic phi_fall;
    logic latch_pt;

    hbb_io_decode #(
        .ADDR_W (ADDR_W),
        .NUM_WIN(NUM_WIN),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) i_decode (
        .addr(cpu_addr),
        .hit (io_hit)
    );

    hbb_phi_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .phi_raw (phi0_in),
        .phi_s   (phi_s),
        .phi_rise(phi_rise),
        .phi_fall(phi_fall)
    );

    hbb_phase_meter #(
        .CNT_W  (CNT_W),
        .RD_LEAD(RD_LEAD)
    ) i_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .phi_s   (phi_s),
        .phi_rise(phi_rise),
        .phi_fall(phi_fall),
        .latch_pt(latch_pt)
    );

    hbb_cycle_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .io_hit    (io_hit),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .phi_rise  (phi_rise),
        .phi_fall  (phi_fall),
        .latch_pt  (latch_pt),
        .host_d_in (host_d_in),
        .cpu_stall (cpu_stall),
        .cpu_done  (cpu_done),
        .cpu_rdata (cpu_rdata),
        .host_a    (host_a),
        .host_rw   (host_rw),
        .host_d_out(host_d_out),
        .host_d_oe (host_d_oe)
    );

    assign cpu_local = cpu_req && !io_hit;

endmodule

// File: rtl/hbb_bridge_chk.sv
module hbb_bridge_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_local,
    input logic              cpu_stall,
    input logic              cpu_done,
    input logic [ADDR_W-1:0] host_a,
    input logic              host_rw,
    input logic              host_d_oe
);
    // R1: a local access never freezes the CPU
    assert_local_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_local) |-> !cpu_stall);

    // R2: completion is a single-cycle pulse
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R2: the CPU runs in the completion cycle
    assert_done_unstalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_stall);

    // R2: the stall is only ever released into a completion cycle
    assert_release_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> cpu_done);

    // R3: the host address moves only while an access holds the CPU
    assert_addr_in_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_a) |-> $past(cpu_stall));

    // R3: direction is back to read by completion
    assert_rw_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> host_rw);

    // R4: the data bus is driven only in a write
    assert_oe_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_d_oe |-> !host_rw);

    // R4: the drive enable is gone before the address changes
    assert_oe_off_before_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_a) |-> !$past(host_d_oe));

endmodule

bind hbb_bridge hbb_bridge_chk #(
    .ADDR_W(ADDR_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_local(cpu_local),
    .cpu_stall(cpu_stall),
    .cpu_done (cpu_done),
    .host_a   (host_a),
    .host_rw  (host_rw),
    .host_d_oe(host_d_oe)
);

// File: tb/test_hbb_bridge.sv
module test_hbb_bridge;
    localparam logic [31:0] W_LO = {16'hE800, 16'hC000};
    localparam logic [31:0] W_HI = {16'hE80F, 16'hC0FF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_local, cpu_stall, cpu_done;
    logic [7:0]  cpu_rdata;
    logic        phi0 = 1'b0;
    logic [15:0] host_a;
    logic        host_rw;
    logic [7:0]  host_d_out;
    logic        host_d_oe;
    logic [7:0]  host_d_in;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished = 0;

    int          hi_len = 25;
    int          lo_len = 25;
    int          pcnt = 0;
    bit          phi_run = 0;
    logic [7:0]  rd_val = 8'h00;
    int          wr_cnt = 0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_oe = 1'b0;
    logic [15:0] rise_addr = '0;
    logic        rise_rw = 1'b0;

    always #2 clk = ~clk;

    // Host model: valid byte only while Phi0 is high, inverted byte otherwise
    assign host_d_in = phi0 ? rd_val : ~rd_val;

    hbb_bridge #(
        .WIN_LO(W_LO),
        .WIN_HI(W_HI)
    ) i_hbb_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .cpu_local (cpu_local),
        .cpu_stall (cpu_stall),
        .cpu_done  (cpu_done),
        .cpu_rdata (cpu_rdata),
        .phi0_in   (phi0),
        .host_a    (host_a),
        .host_rw   (host_rw),
        .host_d_out(host_d_out),
        .host_d_oe (host_d_oe),
        .host_d_in (host_d_in)
    );

    // Phi0 generator and host-side bus monitor
    always @(negedge clk) begin
        if (phi_run) begin
            pcnt = pcnt + 1;
            if (phi0 && pcnt >= hi_len) begin
                if (!host_rw) begin
                    wr_cnt  = wr_cnt + 1;
                    wr_addr = host_a;
                    wr_data = host_d_out;
                    wr_oe   = host_d_oe;
                end
                phi0 = 1'b0;
                pcnt = 0;
            end else if (!phi0 && pcnt >= lo_len) begin
                phi0      = 1'b1;
                pcnt      = 0;
                rise_addr = host_a;
                rise_rw   = host_rw;
            end
        end
    end

    function automatic bit is_io(input logic [15:0] a);
        bit r = 0;
        for (int w = 0; w < 2; w++) begin
            if (a >= W_LO[w*16 +: 16] && a <= W_HI[w*16 +: 16]) r = 1;
        end
        return r;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic do_acc(input logic [15:0] a, input bit we, input logic [7:0] wd,
                          input logic [7:0] rv, input logic [7:0] exp_rd,
                          input bit hold_next, input logic [15:0] next_a);
        int  w0;
        int  n;
        bit  io;
        @(negedge clk);
        rd_val    = rv;
        cpu_req   = 1'b1;
        cpu_addr  = a;
        cpu_we    = we;
        cpu_wdata = wd;
        w0        = wr_cnt;
        io        = is_io(a);
        #1;
        chk("R1/R10 local flag", 32'(cpu_local), 32'(!io));
        chk("R2 stall in request cycle", 32'(cpu_stall), 32'(io));
        if (!io) begin
            @(negedge clk);
            cpu_req = 1'b0;
            chk("R1 no host write for local", 32'(wr_cnt - w0), 32'd0);
            chk("R1 host_rw idle", 32'(host_rw), 32'd1);
        end else begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!cpu_done && n < 3000);
            chk("R2 done reached", 32'(cpu_done), 32'd1);
            chk("R2 no stall in done cycle", 32'(cpu_stall), 32'd0);
            chk("R3 address at data-phase rise", 32'(rise_addr), 32'(a));
            chk("R3 direction at data-phase rise", 32'(rise_rw), 32'(!we));
            if (we) begin
                chk("R4 one write phase", 32'(wr_cnt - w0), 32'd1);
                chk("R4 write address", 32'(wr_addr), 32'(a));
                chk("R4 write byte", 32'(wr_data), 32'(wd));
                chk("R4 drive enable in high phase", 32'(wr_oe), 32'd1);
            end else begin
                chk("R4 no write phase in read", 32'(wr_cnt - w0), 32'd0);
                chk("R5/R6 read byte", 32'(cpu_rdata), 32'(exp_rd));
            end
            if (hold_next) begin
                cpu_addr = next_a;
                cpu_we   = 1'b0;
                #1;
                chk("R7 request ignored in done cycle", 32'(cpu_stall), 32'd0);
            end else begin
                cpu_req = 1'b0;
                @(negedge clk);
                chk("R2 done lasts one cycle", 32'(cpu_done), 32'd0);
            end
        end
    endtask

    task automatic set_speed(input int h, input int l);
        @(negedge clk);
        hi_len = h;
        lo_len = l;
        repeat (3 * (h + l)) @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        phi0 = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 reset stall", 32'(cpu_stall), 32'd0);
        chk("R9 reset done", 32'(cpu_done), 32'd0);
        chk("R9 reset rw", 32'(host_rw), 32'd1);
        chk("R9 reset oe", 32'(host_d_oe), 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9 idle host_a", 32'(host_a), 32'd0);
        chk("R9 idle rw", 32'(host_rw), 32'd1);

        // R6: first data phase has no measured length, capture falls back to the edge
        pcnt    = 0;
        phi_run = 1;
        do_acc(16'hC010, 1'b0, 8'h00, 8'h5A, 8'hA5, 1'b0, 16'h0);
        // R5: length now known, capture before the fall
        do_acc(16'hC011, 1'b0, 8'h00, 8'h3C, 8'h3C, 1'b0, 16'h0);

        // R10 boundaries
        do_acc(16'hBFFF, 1'b0, 8'h00, 8'h11, 8'h11, 1'b0, 16'h0);
        do_acc(16'hC100, 1'b1, 8'h22, 8'h11, 8'h11, 1'b0, 16'h0);
        do_acc(16'hE7FF, 1'b0, 8'h00, 8'h11, 8'h11, 1'b0, 16'h0);
        do_acc(16'hE810, 1'b1, 8'h33, 8'h11, 8'h11, 1'b0, 16'h0);
        do_acc(16'hC000, 1'b1, 8'h81, 8'h00, 8'h00, 1'b0, 16'h0);
        do_acc(16'hC0FF, 1'b0, 8'h00, 8'hC3, 8'hC3, 1'b0, 16'h0);
        do_acc(16'hE800, 1'b0, 8'h00, 8'h96, 8'h96, 1'b0, 16'h0);
        do_acc(16'hE80F, 1'b1, 8'h7E, 8'h00, 8'h00, 1'b0, 16'h0);

        // R7: next I/O request presented inside the done cycle
        do_acc(16'hC020, 1'b1, 8'hA1, 8'h00, 8'h00, 1'b1, 16'hE805);
        do_acc(16'hE805, 1'b0, 8'h00, 8'h4D, 8'h4D, 1'b0, 16'h0);

        // R8: random traffic at three host speeds
        for (int sp = 0; sp < 3; sp++) begin
            if (sp == 1) set_speed(125, 125);
            if (sp == 2) set_speed(30, 70);
            for (int i = 0; i < 20; i++) begin
                logic [15:0] a;
                logic [7:0]  v;
                int          k;
                k = $urandom_range(3, 0);
                if (k == 0) a = 16'hC000 + 16'($urandom_range(255, 0));
                else if (k == 1) a = 16'hE800 + 16'($urandom_range(15, 0));
                else a = 16'($urandom);
                v = 8'($urandom);
                repeat ($urandom_range(hi_len + lo_len, 0)) @(negedge clk);
                do_acc(a, 1'($urandom), 8'($urandom), v, v, 1'b0, 16'h0);
            end
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule